// File: doc/BRIEF.md
# Dual-Mode Serial Result Port

This block hands each finished conversion word to a host over a three- or four-wire serial link. When the conversion engine pulses `load`, the port latches the 16-bit result, applies the selected output coding and pulls its active-low ready flag `rdy_n` low. The host then clocks the word out MSB first. When the last bit has gone, the port raises `rdy_n` and pulses `word_empty` back to the sequencer.

A mode pin picks who owns the serial clock. In master mode the port makes its own serial clock at half the system clock rate and drives it out. Shifting starts by itself once a word is waiting and chip select is low. In slave mode the host supplies the serial clock. The port synchronises that clock and moves to the next bit on each falling edge, so the host can sample on rising edges. In both modes an active-low chip select frames the transfer. While chip select is high, the data driver is released, and in master mode so is the clock driver. Output drivers are modelled as separate enable outputs. If chip select rises in the middle of a word, the transfer is abandoned and the next select restarts the same word from its MSB.

Top module: `srp_result_port`

## Requirements
- R1: After reset `rdy_n` is 1, `word_empty` is 0 and `sdo` is 0.
- R2: `sclk_oe` is 1 only when `master_mode` is 1 and `cs_n` is 0. With `master_mode` at 0 the port never drives the serial clock.
- R3: In master mode, while a word is shifting, `sclk_out` inverts on every system clock cycle, giving half the system clock rate. The first high phase follows the cycle in which `rdy_n` falls.
- R4: The word leaves MSB first and ends with the LSB, 16 bits in all. `sdo` is held unchanged across every rising edge of `sclk_out`.
- R5: While `cs_n` is 1, `sdo_oe` and `sclk_oe` are 0.
- R6: If `cs_n` is already 0 when a word is loaded, master shifting starts without further action. `rdy_n` is 0 in the cycle after `load`, and `sclk_out` is high in the cycle after that.
- R7: If a word is loaded while `cs_n` is 1, no clock runs and `rdy_n` stays 0 until `cs_n` falls. Shifting then starts.
- R8: In master mode `rdy_n` rises, and `word_empty` pulses for exactly one cycle, in the cycle after the last falling step of `sclk_out`. That is 32 cycles after the cycle in which `rdy_n` first reads 0. In slave mode `rdy_n` rises within four system clocks of the 16th falling edge of `sclk_in`.
- R9: With `bipolar` = 1 the raw two's complement result is sent unchanged (0x7FFF, 0x8000, 0xFFFF stay as they are). With `bipolar` = 0 bit 15 is inverted to give offset binary (0x8000 becomes 0x0000, 0x7FFF becomes 0xFFFF). The coding is taken at `load`.
- R10: In slave mode `sdo` moves to the next bit after each falling edge of `sclk_in`. Edges after the 16th give 0 on `sdo`.
- R11: A rise of `cs_n` during a word leaves `rdy_n` at 0. The next fall of `cs_n` resends the whole word from its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (converter) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1: port generates the serial clock; 0: host supplies it |
| bipolar | input | 1 | 1: two's complement output; 0: offset binary |
| load | input | 1 | One-cycle pulse when a conversion word is ready |
| raw_word | input | 16 | Conversion result in two's complement |
| cs_n | input | 1 | Active-low chip select |
| sclk_in | input | 1 | Serial clock from the host (slave mode) |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the data pin |
| rdy_n | output | 1 | Active-low word-waiting flag |
| word_empty | output | 1 | One-cycle pulse when the word has been fully sent |

## Verification
A bit counter that is off by one, or not reset on a deselect, shows up at the ports as a shifted or truncated word at the host. It also moves the rise of `rdy_n` by at least two cycles, and a check on the exact cycle catches that within a single word. A stuck or mis-toggled clock flop shows up within one or two cycles of shifting, either as a missing `sclk_out` high phase or as an `sdo` change on a rising edge. A wrong coding step shows up as a one-bit difference in the MSB of the first word sent with offset-binary selected.

// File: rtl/srp_pkg.sv
package srp_pkg;
    localparam int WORD_W = 16;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic              rdy_n;
        logic              sclk;
        logic              empty;
    } port_state_t;
endpackage

// File: rtl/srp_sclk_sync.sv
module srp_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    output logic fall
);
    // pipe_q[0..STAGES-1] synchronise, pipe_q[STAGES] holds the previous value
    logic [STAGES:0] pipe_q;

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= 1'b0;
                else        pipe_q[g] <= sclk_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= 1'b0;
                else        pipe_q[g] <= pipe_q[g-1];
            end
        end
    end

    assign fall = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/srp_coder.sv
module srp_coder #(
    parameter int W = 16
) (
    input  logic         bipolar,
    input  logic [W-1:0] raw,
    output logic [W-1:0] coded
);
    // offset binary differs from two's complement only in the sign bit
    always_comb begin
        coded = raw;
        if (!bipolar) coded[W-1] = ~raw[W-1];
    end
endmodule

// File: rtl/srp_bit_pick.sv
module srp_bit_pick #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic [W-1:0]  word,
    input  logic [CW-1:0] idx,
    output logic          bit_o
);
    // idx counts bits already sent; idx >= W yields 0
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (idx == CW'(i)) bit_o = word[W-1-i];
        end
    end
endmodule

// File: rtl/srp_result_port.sv
module srp_result_port
    import srp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              bipolar,
    input  logic              load,
    input  logic [WORD_W-1:0] raw_word,
    input  logic              cs_n,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              rdy_n,
    output logic              word_empty
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] DONE_IDX = CNT_W'(WORD_W);

    port_state_t       st_d, st_q;
    logic [WORD_W-1:0] coded;
    logic              host_fall;
    logic              cur_bit;

    srp_coder #(.W(WORD_W)) coder_i (
        .bipolar (bipolar),
        .raw     (raw_word),
        .coded   (coded)
    );

    srp_sclk_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_raw (sclk_in),
        .fall     (host_fall)
    );

    srp_bit_pick #(.W(WORD_W), .CW(CNT_W)) pick_i (
        .word  (st_q.word),
        .idx   (st_q.cnt),
        .bit_o (cur_bit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.empty = 1'b0;
        if (load) begin
            st_d.word  = coded;
            st_d.cnt   = '0;
            st_d.rdy_n = 1'b0;
            st_d.sclk  = 1'b0;
        end else if (cs_n) begin
            // deselect: stop the clock and rewind a pending word
            st_d.sclk = 1'b0;
            if (!st_q.rdy_n) st_d.cnt = '0;
        end else if (st_q.rdy_n) begin
            st_d.sclk = 1'b0;
        end else if (master_mode) begin
            st_d.sclk = ~st_q.sclk;
            if (st_q.sclk) begin
                if (st_q.cnt == LAST_IDX) begin
                    st_d.cnt   = DONE_IDX;
                    st_d.rdy_n = 1'b1;
                    st_d.empty = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else begin
            st_d.sclk = 1'b0;
            if (host_fall) begin
                if (st_q.cnt == LAST_IDX) begin
                    st_d.cnt   = DONE_IDX;
                    st_d.rdy_n = 1'b1;
                    st_d.empty = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word  <= '0;
            st_q.cnt   <= DONE_IDX;
            st_q.rdy_n <= 1'b1;
            st_q.sclk  <= 1'b0;
            st_q.empty <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_out   = st_q.sclk;
    assign sclk_oe    = master_mode & ~cs_n;
    assign sdo        = cur_bit;
    assign sdo_oe     = ~cs_n;
    assign rdy_n      = st_q.rdy_n;
    assign word_empty = st_q.empty;
endmodule

// File: rtl/srp_result_port_chk.sv
module srp_result_port_chk (
    input logic clk,
    input logic rst_n,
    input logic master_mode,
    input logic load,
    input logic cs_n,
    input logic sclk_out,
    input logic sclk_oe,
    input logic sdo,
    input logic sdo_oe,
    input logic rdy_n,
    input logic word_empty
);
    p_float_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sdo_oe && !sclk_oe));

    p_slave_no_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> !sclk_oe);

    p_half_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(master_mode && !cs_n && !rdy_n && !load) |-> (sclk_out != $past(sclk_out)));

    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && $rose(sclk_out)) |-> $stable(sdo));

    p_empty_with_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_empty |-> $rose(rdy_n));

    p_idle_clock_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_n |-> !sclk_out);
endmodule

bind srp_result_port srp_result_port_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .load        (load),
    .cs_n        (cs_n),
    .sclk_out    (sclk_out),
    .sclk_oe     (sclk_oe),
    .sdo         (sdo),
    .sdo_oe      (sdo_oe),
    .rdy_n       (rdy_n),
    .word_empty  (word_empty)
);

// File: tb/srp_result_port_tb_top.sv
module srp_result_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_mode = 1'b1;
    logic        bipolar = 1'b1;
    logic        load = 1'b0;
    logic [15:0] raw_word = '0;
    logic        cs_n = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sclk_out, sclk_oe, sdo, sdo_oe, rdy_n, word_empty;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];

    always #5 clk = ~clk;

    srp_result_port dut_i (
        .clk (clk), .rst_n (rst_n), .master_mode (master_mode), .bipolar (bipolar),
        .load (load), .raw_word (raw_word), .cs_n (cs_n), .sclk_in (sclk_in),
        .sclk_out (sclk_out), .sclk_oe (sclk_oe), .sdo (sdo), .sdo_oe (sdo_oe),
        .rdy_n (rdy_n), .word_empty (word_empty)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] code_of(input logic [15:0] raw, input logic bp);
        return bp ? raw : (raw ^ 16'h8000);
    endfunction

    // monitor: collects master-mode bits on sclk_out rising, pops and compares
    int          mon_bits = 0;
    logic        mon_prev = 1'b0;
    logic [15:0] mon_acc  = '0;
    always @(negedge clk) begin
        if (!rst_n || cs_n || !master_mode) begin
            mon_bits = 0;
            mon_prev = 1'b0;
        end else begin
            if (sclk_out && !mon_prev) begin
                mon_acc = {mon_acc[14:0], sdo};
                mon_bits++;
                if (mon_bits == 16) begin
                    mon_bits = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected word", {16'h0, mon_acc}, 32'h0);
                    end else begin
                        logic [15:0] e;
                        e = exp_q.pop_front();
                        check(mon_acc == e, "R4/R9 master word", {16'h0, mon_acc}, {16'h0, e});
                    end
                end
            end
            mon_prev = sclk_out;
        end
    end

    // driver: load a word with cs_n already low and check the master timing
    task automatic run_master(input logic [15:0] raw, input logic bp);
        @(negedge clk);
        load = 1'b1; raw_word = raw; bipolar = bp;
        exp_q.push_back(code_of(raw, bp));
        @(negedge clk);
        load = 1'b0;
        check(rdy_n == 1'b0, "R6 rdy_n low after load", {31'h0, rdy_n}, 32'h0);
        check(sclk_out == 1'b0, "R6 sclk low first", {31'h0, sclk_out}, 32'h0);
        @(negedge clk);
        check(sclk_out == 1'b1, "R3 sclk high", {31'h0, sclk_out}, 32'h1);
        @(negedge clk);
        check(sclk_out == 1'b0, "R3 sclk low", {31'h0, sclk_out}, 32'h0);
        repeat (29) @(negedge clk);
        check(rdy_n == 1'b0, "R8 rdy_n still low", {31'h0, rdy_n}, 32'h0);
        @(negedge clk);
        check(rdy_n && word_empty, "R8 rdy_n rise with empty", {30'h0, rdy_n, word_empty}, 32'h3);
        @(negedge clk);
        check(word_empty == 1'b0, "R8 empty one cycle", {31'h0, word_empty}, 32'h0);
        check(exp_q.size() == 0, "R4 word delivered", exp_q.size(), 32'h0);
    endtask

    // slave-mode host: samples sdo before each rising edge of sclk_in
    task automatic run_slave(input logic [15:0] raw, input logic bp);
        logic [15:0] acc;
        logic [15:0] e;
        master_mode = 1'b0;
        cs_n = 1'b0;
        @(negedge clk);
        load = 1'b1; raw_word = raw; bipolar = bp;
        exp_q.push_back(code_of(raw, bp));
        @(negedge clk);
        load = 1'b0;
        repeat (2) @(negedge clk);
        check(sclk_oe == 1'b0, "R2 slave clock not driven", {31'h0, sclk_oe}, 32'h0);
        acc = '0;
        for (int i = 0; i < 16; i++) begin
            acc = {acc[14:0], sdo};
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            sclk_in = 1'b0;
            repeat (6) @(negedge clk);
        end
        e = exp_q.pop_front();
        check(acc == e, "R10/R9 slave word", {16'h0, acc}, {16'h0, e});
        check(rdy_n == 1'b1, "R8 slave rdy_n rise", {31'h0, rdy_n}, 32'h1);
        check(sdo == 1'b0, "R10 extra edge zero", {31'h0, sdo}, 32'h0);
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        sclk_in = 1'b0;
        repeat (6) @(negedge clk);
        check(sdo == 1'b0, "R10 zero after extra edge", {31'h0, sdo}, 32'h0);
        cs_n = 1'b1;
        master_mode = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy_n == 1'b1, "R1 reset rdy_n", {31'h0, rdy_n}, 32'h1);
        check(word_empty == 1'b0, "R1 reset empty", {31'h0, word_empty}, 32'h0);
        check(sdo == 1'b0, "R1 reset sdo", {31'h0, sdo}, 32'h0);
        check(!sdo_oe && !sclk_oe, "R5 deselected drivers off", {30'h0, sdo_oe, sclk_oe}, 32'h0);

        cs_n = 1'b0;
        @(negedge clk);
        check(sclk_oe == 1'b1, "R2 master drives clock", {31'h0, sclk_oe}, 32'h1);
        check(sdo_oe == 1'b1, "R5 selected data driven", {31'h0, sdo_oe}, 32'h1);

        run_master(16'h7FFF, 1'b1);
        run_master(16'h8000, 1'b1);
        run_master(16'hFFFF, 1'b1);
        run_master(16'h8000, 1'b0);
        run_master(16'h7FFF, 1'b0);
        run_master(16'h1234, 1'b0);

        // R7: load while deselected, then select
        cs_n = 1'b1;
        @(negedge clk);
        load = 1'b1; raw_word = 16'hA5C3; bipolar = 1'b1;
        exp_q.push_back(16'hA5C3);
        @(negedge clk);
        load = 1'b0;
        repeat (5) @(negedge clk);
        check(rdy_n == 1'b0 && sclk_out == 1'b0, "R7 waits for select", {30'h0, rdy_n, sclk_out}, 32'h0);
        cs_n = 1'b0;
        for (int k = 0; k < 40 && !rdy_n; k++) @(negedge clk);
        check(rdy_n == 1'b1, "R7 word sent after select", {31'h0, rdy_n}, 32'h1);
        check(exp_q.size() == 0, "R7 word received", exp_q.size(), 32'h0);

        // R11: abandon mid-word, then resend from MSB
        cs_n = 1'b1;
        @(negedge clk);
        load = 1'b1; raw_word = 16'h5A3C; bipolar = 1'b1;
        exp_q.push_back(16'h5A3C);
        @(negedge clk);
        load = 1'b0;
        cs_n = 1'b0;
        repeat (11) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        check(!sdo_oe && !sclk_oe, "R5 drivers off mid-word", {30'h0, sdo_oe, sclk_oe}, 32'h0);
        check(rdy_n == 1'b0, "R11 word still pending", {31'h0, rdy_n}, 32'h0);
        repeat (3) @(negedge clk);
        cs_n = 1'b0;
        for (int k = 0; k < 40 && !rdy_n; k++) @(negedge clk);
        check(rdy_n == 1'b1, "R11 resend finished", {31'h0, rdy_n}, 32'h1);
        check(exp_q.size() == 0, "R11 full word resent", exp_q.size(), 32'h0);

        cs_n = 1'b1;
        @(negedge clk);
        run_slave(16'hC0DE, 1'b1);
        run_slave(16'h0001, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule